// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block lets an 8-bit direct register port reach a bank of 16-bit indirect registers. It occupies four consecutive direct addresses starting at a base. Host software places a 16-bit word in two data byte registers and then writes an 8-bit indirect address. The address write is what launches a request. If a data byte was written since the previous request, the request is a write of that word. If no data byte was written, the request is a read, and the fetched word is returned into the two data byte registers.

Each request is serviced a fixed number of clock cycles after its address write, which stands for waiting on an internal processing slot. A busy flag stays up for that whole time. When the access completes, a pending flag is set. That flag drives an interrupt output through its own enable bit. Addresses past the implemented bank are reserved. Reads of them return zero, writes to them are discarded, and both still complete and set the pending flag.

Top module: `ira_bridge`

## Requirements
- R1: After reset the data low byte, the data high byte, the address register and the status register all read 0x00, and `irq` is low.
- R2: Writing a data byte (offset 0 = bits 7:0, offset 1 = bits 15:8) and then the address register (offset 2) requests a write of the 16-bit word to that indirect address. A later read of that address returns the word, and the data bytes keep the written value.
- R3: Writing the address register with no data byte write since the previous request requests a read. After completion the word appears in the data bytes, with bits 7:0 at offset 0 and bits 15:8 at offset 1.
- R4: Status bit 0 (busy) reads 1 in each of the LATENCY cycles that follow the address-write edge, and reads 0 after the LATENCY-th edge. The default LATENCY is 4.
- R5: An address write while busy is ignored. The address register keeps the value of the request in service, busy falls at the original time, and that request's result is unaffected.
- R6: Completion sets status bit 1 (pending). `irq` is high exactly when pending and status bit 2 (enable) are both 1. Enable is written through bit 2 of a status write.
- R7: A status write with bit 1 = 1 clears pending, and a status write with bit 1 = 0 leaves it unchanged. When a completion and a clearing write fall on the same edge, pending ends up set.
- R8: An indirect address at or above NUM_REGS (default 32) is reserved. A read of it returns 0x0000 and still sets pending. A write to it is discarded.
- R9: A write request carries the data register contents at the moment of its address write. Data byte writes made while busy do not alter that request, and they mark the next address write as a write request.
- R10: Writes to direct addresses outside the four-register window have no effect, and reads of such addresses return 0x00. With the default base 0x1C, the window is 0x1C to 0x1F.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Direct register write strobe |
| reg_addr | input | DADDR_W (8) | Direct register address |
| reg_wdata | input | 8 | Direct register write data |
| reg_rdata | output | 8 | Direct register read data, combinational from reg_addr |
| irq | output | 1 | Serviced-request interrupt, pending AND enable |

## Verification
Two functions can land on the same edge: the completion that sets pending, and a host status write that clears it. The bench launches a read request, waits two cycles, and then schedules a status write with bit 1 set so that it lands exactly on the LATENCY-th edge. The run passes only if pending and `irq` still read 1 afterwards, and a following clear then drops them. A second collision places an address write inside the busy window and judges that the address readback, the fall time of busy and the returned word all belong to the first request.

// File: rtl/ira_pkg.sv
package ira_pkg;

    localparam int REG_W   = 8;
    localparam int WORD_W  = 16;
    localparam int IADDR_W = 8;
    localparam int NBYTES  = WORD_W / REG_W;

    localparam int ST_BUSY = 0;
    localparam int ST_PEND = 1;
    localparam int ST_IEN  = 2;

    typedef enum logic [2:0] {
        SEL_DLO,
        SEL_DHI,
        SEL_ADDR,
        SEL_STAT,
        SEL_NONE
    } dsel_e;

    typedef struct packed {
        logic               is_write;
        logic [IADDR_W-1:0] addr;
        logic [WORD_W-1:0]  wdata;
    } req_t;

    function automatic dsel_e off_to_sel(input logic [1:0] off);
        case (off)
            2'd0:    return SEL_DLO;
            2'd1:    return SEL_DHI;
            2'd2:    return SEL_ADDR;
            default: return SEL_STAT;
        endcase
    endfunction

endpackage

// File: rtl/ira_bank.sv
module ira_bank
    import ira_pkg::*;
#(
    parameter int NUM_REGS = 32
) (
    input  logic               clk,
    input  logic               we,
    input  logic [IADDR_W-1:0] addr,
    input  logic [WORD_W-1:0]  wdata,
    output logic [WORD_W-1:0]  rdata
);
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam logic [IADDR_W:0] LIMIT = NUM_REGS[IADDR_W:0];

    logic [WORD_W-1:0] mem [NUM_REGS];
    logic              in_range;
    logic [IDX_W-1:0]  idx;

    assign in_range = ({1'b0, addr} < LIMIT);
    assign idx      = addr[IDX_W-1:0];

    // contents are intentionally not reset
    always_ff @(posedge clk) begin
        if (we && in_range)
            mem[idx] <= wdata;
    end

    assign rdata = in_range ? mem[idx] : '0;

endmodule

// File: rtl/ira_seq.sv
module ira_seq
    import ira_pkg::*;
#(
    parameter int LATENCY = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               start_write,
    input  logic [IADDR_W-1:0] start_addr,
    input  logic [WORD_W-1:0]  start_data,
    output logic               busy,
    output logic               done,
    output req_t               req
);
    localparam int CNT_W = $clog2(LATENCY) + 1;

    logic [CNT_W-1:0] cnt;

    assign done = busy && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
            req  <= '0;
        end else if (start) begin
            busy         <= 1'b1;
            cnt          <= CNT_W'(LATENCY - 1);
            req.is_write <= start_write;
            req.addr     <= start_addr;
            req.wdata    <= start_data;
        end else if (done) begin
            busy <= 1'b0;
        end else if (busy) begin
            cnt <= cnt - 1'b1;
        end
    end

endmodule

// File: rtl/ira_hostregs.sv
module ira_hostregs
    import ira_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NBYTES-1:0]  data_we,
    input  logic               addr_we,
    input  logic               stat_we,
    input  logic [REG_W-1:0]   wdata,
    input  logic               busy,
    input  logic               done,
    input  logic               done_read,
    input  logic [WORD_W-1:0]  rd_word,
    output logic [WORD_W-1:0]  data_q,
    output logic [IADDR_W-1:0] addr_q,
    output logic               dirty_q,
    output logic               pend_q,
    output logic               ien_q,
    output logic               start
);
    logic [REG_W-1:0] byte_q [NBYTES];

    assign start = addr_we && !busy;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst)
                byte_q[b] <= '0;
            else if (data_we[b])
                byte_q[b] <= wdata;
            else if (done_read)
                byte_q[b] <= rd_word[b*REG_W +: REG_W];
        end
        assign data_q[b*REG_W +: REG_W] = byte_q[b];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            dirty_q <= 1'b0;
            pend_q  <= 1'b0;
            ien_q   <= 1'b0;
        end else begin
            if (start)
                addr_q <= wdata;

            if (|data_we)
                dirty_q <= 1'b1;
            else if (start || done_read)
                dirty_q <= 1'b0;

            // completion wins over a same-edge clear
            if (done)
                pend_q <= 1'b1;
            else if (stat_we && wdata[ST_PEND])
                pend_q <= 1'b0;

            if (stat_we)
                ien_q <= wdata[ST_IEN];
        end
    end

endmodule

// File: rtl/ira_bridge.sv
module ira_bridge
    import ira_pkg::*;
#(
    parameter int DADDR_W  = 8,
    parameter int BASE     = 28,
    parameter int NUM_REGS = 32,
    parameter int LATENCY  = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic [DADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    output logic               irq
);
    localparam logic [DADDR_W-1:0] BASE_V = BASE[DADDR_W-1:0];
    localparam logic [DADDR_W-1:0] WIN    = DADDR_W'(4);

    logic [DADDR_W-1:0] off;
    dsel_e              sel;
    logic [NBYTES-1:0]  data_we;
    logic               host_data_wr;
    logic               addr_wr;
    logic               stat_we;

    logic [WORD_W-1:0]  data_q;
    logic [IADDR_W-1:0] addr_q;
    logic               dirty_q;
    logic               pend_q;
    logic               ien_q;
    logic               start;
    logic               busy;
    logic               done;
    logic               done_read;
    req_t               req;
    logic [WORD_W-1:0]  bank_rdata;

    assign off = reg_addr - BASE_V;
    assign sel = (off < WIN) ? off_to_sel(off[1:0]) : SEL_NONE;

    assign data_we[0]   = reg_wr && (sel == SEL_DLO);
    assign data_we[1]   = reg_wr && (sel == SEL_DHI);
    assign host_data_wr = |data_we;
    assign addr_wr      = reg_wr && (sel == SEL_ADDR);
    assign stat_we      = reg_wr && (sel == SEL_STAT);
    assign done_read    = done && !req.is_write;

    ira_hostregs u_hostregs (
        .clk       (clk),
        .rst       (rst),
        .data_we   (data_we),
        .addr_we   (addr_wr),
        .stat_we   (stat_we),
        .wdata     (reg_wdata),
        .busy      (busy),
        .done      (done),
        .done_read (done_read),
        .rd_word   (bank_rdata),
        .data_q    (data_q),
        .addr_q    (addr_q),
        .dirty_q   (dirty_q),
        .pend_q    (pend_q),
        .ien_q     (ien_q),
        .start     (start)
    );

    ira_seq #(.LATENCY(LATENCY)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .start_write (dirty_q),
        .start_addr  (reg_wdata),
        .start_data  (data_q),
        .busy        (busy),
        .done        (done),
        .req         (req)
    );

    ira_bank #(.NUM_REGS(NUM_REGS)) u_bank (
        .clk   (clk),
        .we    (done && req.is_write),
        .addr  (req.addr),
        .wdata (req.wdata),
        .rdata (bank_rdata)
    );

    always_comb begin
        case (sel)
            SEL_DLO:  reg_rdata = data_q[REG_W-1:0];
            SEL_DHI:  reg_rdata = data_q[WORD_W-1:REG_W];
            SEL_ADDR: reg_rdata = addr_q;
            SEL_STAT: reg_rdata = {{(REG_W-3){1'b0}}, ien_q, pend_q, busy};
            default:  reg_rdata = '0;
        endcase
    end

    assign irq = pend_q && ien_q;

endmodule

// File: rtl/ira_bridge_chk.sv
module ira_bridge_chk
    import ira_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int LATENCY  = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               busy,
    input logic               done,
    input logic               pend,
    input logic               req_is_write,
    input logic [IADDR_W-1:0] req_addr,
    input logic [IADDR_W-1:0] addr_q,
    input logic [WORD_W-1:0]  data_q,
    input logic               host_data_wr,
    input logic               addr_wr
);
    localparam logic [IADDR_W:0] LIMIT = NUM_REGS[IADDR_W:0];

    logic [15:0] bcnt;

    always_ff @(posedge clk) begin
        if (rst)
            bcnt <= '0;
        else if (busy)
            bcnt <= bcnt + 1'b1;
        else
            bcnt <= '0;
    end

    p_busy_bound_r4: assert property (@(posedge clk) disable iff (rst)
        busy |-> (bcnt < 16'(LATENCY)));

    p_done_idle_r4: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    p_addr_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (busy && addr_wr) |=> $stable(addr_q));

    p_pend_src_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(pend) |-> $past(done));

    p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> pend);

    p_reserved_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (done && !req_is_write && ({1'b0, req_addr} >= LIMIT) && !host_data_wr)
        |=> (data_q == '0));

endmodule

bind ira_bridge ira_bridge_chk #(.NUM_REGS(NUM_REGS), .LATENCY(LATENCY)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .busy         (busy),
    .done         (done),
    .pend         (pend_q),
    .req_is_write (req.is_write),
    .req_addr     (req.addr),
    .addr_q       (addr_q),
    .data_q       (data_q),
    .host_data_wr (host_data_wr),
    .addr_wr      (addr_wr)
);

// File: tb/ira_bridge_bench.sv
module ira_bridge_bench;

    localparam int NUM_REGS = 32;
    localparam int LATENCY  = 4;
    localparam logic [7:0] A_DLO = 8'h1C;
    localparam logic [7:0] A_DHI = 8'h1D;
    localparam logic [7:0] A_ADR = 8'h1E;
    localparam logic [7:0] A_ST  = 8'h1F;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq;

    int  total = 0;
    int  bad = 0;
    bit  finished = 1'b0;

    logic [15:0] exp_mem [256];
    bit          valid [256];

    always #5 clk = ~clk;

    ira_bridge #(.DADDR_W(8), .BASE(28), .NUM_REGS(NUM_REGS), .LATENCY(LATENCY)) u_ira_bridge (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic dwr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic drd(input logic [7:0] a, output logic [7:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        for (int k = 0; k < 20; k++) begin
            drd(A_ST, s);
            if (s[0] == 1'b0) break;
            @(negedge clk);
        end
    endtask

    task automatic get_word(output logic [15:0] w);
        logic [7:0] lo, hi;
        drd(A_DLO, lo);
        drd(A_DHI, hi);
        w = {hi, lo};
    endtask

    function automatic logic [15:0] model_read(input logic [7:0] a);
        if (a >= NUM_REGS) return 16'h0000;
        return exp_mem[a];
    endfunction

    task automatic ind_write(input logic [7:0] a, input logic [15:0] d);
        dwr(A_DLO, d[7:0]);
        dwr(A_DHI, d[15:8]);
        dwr(A_ADR, a);
        wait_idle();
        if (a < NUM_REGS) begin
            exp_mem[a] = d;
            valid[a]   = 1'b1;
        end
    endtask

    task automatic ind_read(input logic [7:0] a, output logic [15:0] w);
        dwr(A_ADR, a);
        wait_idle();
        get_word(w);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL R4 watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0]  v;
        logic [15:0] w;
        for (int i = 0; i < 256; i++) begin
            exp_mem[i] = 16'h0;
            valid[i]   = 1'b0;
        end
        void'($urandom(32'd20061));

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        drd(A_DLO, v); chk("R1 data low", {8'h0, v}, 16'h0);
        drd(A_DHI, v); chk("R1 data high", {8'h0, v}, 16'h0);
        drd(A_ADR, v); chk("R1 address", {8'h0, v}, 16'h0);
        drd(A_ST, v);  chk("R1 status", {8'h0, v}, 16'h0);
        chk("R1 irq", {15'h0, irq}, 16'h0);

        // R2 write then read back, R4 busy window
        dwr(A_DLO, 8'h34);
        dwr(A_DHI, 8'h12);
        dwr(A_ADR, 8'h05);
        drd(A_ST, v); chk("R4 busy after addr write", {15'h0, v[0]}, 16'h1);
        for (int k = 1; k < LATENCY; k++) begin
            @(negedge clk);
            drd(A_ST, v); chk("R4 busy held", {15'h0, v[0]}, 16'h1);
        end
        @(negedge clk);
        drd(A_ST, v); chk("R4 busy dropped", {15'h0, v[0]}, 16'h0);
        chk("R6 pending after write", {15'h0, v[1]}, 16'h1);
        chk("R6 irq masked", {15'h0, irq}, 16'h0);
        exp_mem[5] = 16'h1234; valid[5] = 1'b1;
        get_word(w); chk("R2 data kept", w, 16'h1234);
        dwr(A_ST, 8'h02);
        ind_write(8'h1F, 16'hBEEF);
        ind_write(8'h00, 16'h00FF);
        ind_read(8'h05, w); chk("R2 readback 0x05", w, 16'h1234);
        ind_read(8'h1F, w); chk("R3 readback top addr", w, 16'hBEEF);
        ind_read(8'h00, w); chk("R3 readback addr 0", w, 16'h00FF);
        drd(A_ADR, v); chk("R3 address readback", {8'h0, v}, 16'h0000);

        // R6 enable and irq
        dwr(A_ST, 8'h06);
        drd(A_ST, v); chk("R7 clear by one", {15'h0, v[1]}, 16'h0);
        chk("R6 irq low when clear", {15'h0, irq}, 16'h0);
        ind_read(8'h05, w);
        chk("R6 irq high", {15'h0, irq}, 16'h1);
        dwr(A_ST, 8'h04);
        drd(A_ST, v); chk("R7 write zero keeps pending", {15'h0, v[1]}, 16'h1);
        dwr(A_ST, 8'h06);

        // R7 same edge: completion vs clear
        dwr(A_ADR, 8'h1F);
        repeat (2) @(negedge clk);
        dwr(A_ST, 8'h06);
        drd(A_ST, v);
        chk("R7 set wins busy low", {15'h0, v[0]}, 16'h0);
        chk("R7 set wins pending", {15'h0, v[1]}, 16'h1);
        chk("R7 set wins irq", {15'h0, irq}, 16'h1);
        get_word(w); chk("R3 collision read word", w, 16'hBEEF);
        dwr(A_ST, 8'h06);
        drd(A_ST, v); chk("R7 later clear", {15'h0, v[1]}, 16'h0);

        // R5 address write while busy
        dwr(A_ADR, 8'h05);
        dwr(A_ADR, 8'h00);
        drd(A_ADR, v); chk("R5 address held", {8'h0, v}, 16'h0005);
        @(negedge clk);
        drd(A_ST, v); chk("R5 busy still up", {15'h0, v[0]}, 16'h1);
        @(negedge clk);
        drd(A_ST, v); chk("R5 busy at original time", {15'h0, v[0]}, 16'h0);
        get_word(w); chk("R5 first request word", w, 16'h1234);
        dwr(A_ST, 8'h06);

        // R8 reserved addresses
        ind_read(8'h20, w); chk("R8 reserved read zero", w, 16'h0);
        drd(A_ST, v); chk("R8 reserved completes", {15'h0, v[1]}, 16'h1);
        dwr(A_ST, 8'h06);
        ind_write(8'h21, 16'hA5A5);
        ind_read(8'h21, w); chk("R8 reserved write dropped", w, 16'h0);
        ind_read(8'h01 + 8'd0, w);
        dwr(A_ST, 8'h06);

        // R9 data snapshot and write marking during busy
        dwr(A_DLO, 8'h11);
        dwr(A_DHI, 8'h22);
        dwr(A_ADR, 8'h07);
        dwr(A_DLO, 8'h33);
        dwr(A_DHI, 8'h44);
        wait_idle();
        get_word(w); chk("R9 new data kept", w, 16'h4433);
        dwr(A_ADR, 8'h08);
        wait_idle();
        exp_mem[7] = 16'h2211; valid[7] = 1'b1;
        exp_mem[8] = 16'h4433; valid[8] = 1'b1;
        ind_read(8'h07, w); chk("R9 snapshot word", w, 16'h2211);
        ind_read(8'h08, w); chk("R9 next request was write", w, 16'h4433);
        dwr(A_ST, 8'h06);

        // R10 outside the window
        dwr(8'h20, 8'h5A);
        dwr(8'h1B, 8'hC3);
        drd(8'h20, v); chk("R10 read outside zero", {8'h0, v}, 16'h0);
        drd(8'h1B, v); chk("R10 read below zero", {8'h0, v}, 16'h0);
        drd(A_ST, v); chk("R10 status untouched", {8'h0, v}, 16'h0004);
        drd(A_ADR, v); chk("R10 address untouched", {8'h0, v}, 16'h0008);
        get_word(w); chk("R10 data untouched", w, 16'h4433);

        // random mix
        for (int it = 0; it < 150; it++) begin
            logic [7:0]  a;
            logic [15:0] d;
            logic        en;
            bit          rd_op;
            a     = 8'($urandom % (NUM_REGS + 8));
            d     = 16'($urandom);
            en    = 1'($urandom % 2);
            rd_op = ($urandom % 2) == 0;
            dwr(A_ST, {5'b0, en, 1'b1, 1'b0});
            if (rd_op && (a >= NUM_REGS || valid[a])) begin
                ind_read(a, w);
                chk("R3 random read", w, model_read(a));
            end else begin
                ind_write(a, d);
                get_word(w);
                chk("R2 random data kept", w, d);
            end
            drd(A_ST, v);
            chk("R6 random pending", {15'h0, v[1]}, 16'h1);
            chk("R6 random irq", {15'h0, irq}, {15'h0, en});
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule